// File: doc/BRIEF.md
# Power Stage Configuration-Check Sequencer

This block runs the startup of a dual-output converter whose six switching stages are split between the two outputs by a 2-bit strap. Once bias power is good, it captures the strap a single time. When the start conditions are met, it checks the wiring. It drives a short pulse on the fixed master stage of output 1 and records which stages see that pulse. It then does the same for the master stage of output 2. The two recorded sets are compared with the partition that the captured strap selects.

If the wiring matches, the block sets a sticky status bit and grants soft-start to each enabled output after a fixed wait. If it does not match, the block waits the same interval and runs the whole check again. It keeps retrying until the wiring matches or bias power goes away. All timing is counted in cycles of the system clock. The per-stage detect inputs are asynchronous and each passes through a two-flop synchroniser.

Top module: `pstage_cfg_seq`

## Requirements
- R1: Stage bit i of `stage_det` and `pd_en` stands for stage i+1. Stage 2 (bit 1) is the master of output 1 and stage 5 (bit 4) is the master of output 2. The captured strap selects which stages belong to output 2: code 3 gives stages 4,5,6; code 2 gives 5,6; code 1 gives 5 only; code 0 gives 3,4,5,6. Every other stage belongs to output 1. With wiring that matches the strap, the check passes.
- R2: The strap is captured on the first clock after `bias_ok` is seen high. Later changes on the strap pins have no effect until `bias_ok` has gone low again.
- R3: A check starts only when `bias_ok`, `pwr_ok` and `sys_en` are all high and at least one bit of `ch_en` is high.
- R4: A check drives `probe_req[0]` (output-1 master) for exactly PULSE_CYC cycles. It then drives `probe_req[1]` (output-2 master) for exactly PULSE_CYC cycles. The two bits are never high together.
- R5: `pd_en` equals 6'b101101 (stages 1, 3, 4 and 6) while either probe bit is high, and is zero at all other times.
- R6: Each detect bit is synchronised and sampled on the last cycle of its pulse window. The check fails unless the first sample equals the output-1 stage set and the second equals the output-2 stage set. If the two masters are shorted together, the check fails.
- R7: After a passing check, `cfg_ok` rises GAP_CYC cycles after `probe_req[1]` falls.
- R8: After a failing check, `probe_req[0]` rises again GAP_CYC cycles after `probe_req[1]` falls. This repeats for every failure.
- R9: `cfg_ok` is sticky while `bias_ok` is high. No further check runs after a pass. Enabling an output afterwards grants it soft-start with no probing.
- R10: `ss_grant[i]` is high exactly one clock after a cycle in which `cfg_ok` (next value), `sys_en`, `pwr_ok` and `ch_en[i]` were all high.
- R11: When `bias_ok` goes low, the block clears `cfg_ok` and the grants and aborts any check. This takes priority over a check that completes in the same cycle.
- R12: If the start conditions are lost during a check or its wait, the check is abandoned. It restarts from the output-1 pulse once the conditions return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply reset condition satisfied |
| pwr_ok | input | 1 | Power-input supply reset condition satisfied |
| sys_en | input | 1 | System enable |
| ch_en | input | 2 | Per-output enables |
| strap | input | 2 | Stage partition strap |
| stage_det | input | 6 | Asynchronous per-stage pulse detect |
| probe_req | output | 2 | Master pulse request, bit 0 output 1, bit 1 output 2 |
| pd_en | output | 6 | Pull-down enable for non-master stages |
| ss_grant | output | 2 | Per-output soft-start grant |
| cfg_ok | output | 1 | Sticky wiring-check pass status |

## Verification
The sharpest collision is between the last cycle of a passing post-check wait and a drop of `bias_ok`. The wait would raise `cfg_ok` on that edge, but the bias loss must clear it. The bench counts cycles from the falling edge of the second probe and lowers `bias_ok` exactly for the expiry edge. It then expects `cfg_ok` and both grants to stay low. A second pairing follows the same pattern: the end of a failing wait coincides with the start of the next probe, and the bench judges the retry by seeing the output-1 pulse on exactly that cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int NSTG   = 6;
    localparam int M1_IDX = 1;   // stage 2
    localparam int M2_IDX = 4;   // stage 5

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRB1,
        ST_PRB2,
        ST_WAIT,
        ST_DONE
    } seq_st_e;

endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic ff1_q, ff2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ff1_q <= 1'b0;
                ff2_q <= 1'b0;
            end else begin
                ff1_q <= async_i[g];
                ff2_q <= ff1_q;
            end
        end
        assign sync_o[g] = ff2_q;
    end
endmodule

// File: rtl/pcs_cfg_decode.sv
module pcs_cfg_decode
    import pcs_pkg::*;
(
    input  logic [1:0]      code,
    output logic [NSTG-1:0] grp1_mask,
    output logic [NSTG-1:0] grp2_mask
);
    always_comb begin
        unique case (code)
            2'b11:   grp2_mask = 6'b111000;
            2'b10:   grp2_mask = 6'b110000;
            2'b01:   grp2_mask = 6'b010000;
            default: grp2_mask = 6'b111100;
        endcase
        grp1_mask = ~grp2_mask;
    end
endmodule

// File: rtl/pstage_cfg_seq.sv
module pstage_cfg_seq
    import pcs_pkg::*;
#(
    parameter int PULSE_CYC = 20,      // probe width, must be >= 3
    parameter int GAP_CYC   = 20000    // wait after a check
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bias_ok,
    input  logic       pwr_ok,
    input  logic       sys_en,
    input  logic [1:0] ch_en,
    input  logic [1:0] strap,
    input  logic [5:0] stage_det,
    output logic [1:0] probe_req,
    output logic [5:0] pd_en,
    output logic [1:0] ss_grant,
    output logic       cfg_ok
);
    localparam int CNT_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYC - 1);
    localparam logic [NSTG-1:0] MST_MASK =
        (NSTG'(1) << M1_IDX) | (NSTG'(1) << M2_IDX);
    localparam logic [NSTG-1:0] PD_MASK  = ~MST_MASK;

    typedef struct packed {
        seq_st_e         st;
        logic [CW-1:0]   cnt;
        logic [1:0]      strap;
        logic            strap_vld;
        logic [NSTG-1:0] cap1;
        logic            pass;
        logic            cfg_ok;
        logic [1:0]      grant;
    } regs_t;

    regs_t q, d;

    logic [NSTG-1:0] det_s;
    logic [NSTG-1:0] m1, m2;
    logic            go_ok;

    pcs_sync #(.W(NSTG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stage_det),
        .sync_o  (det_s)
    );

    pcs_cfg_decode u_dec (
        .code      (q.strap),
        .grp1_mask (m1),
        .grp2_mask (m2)
    );

    assign go_ok = bias_ok && pwr_ok && sys_en && (|ch_en) && q.strap_vld;

    always_comb begin
        d = q;
        if (!bias_ok) begin
            d.st        = ST_IDLE;
            d.cnt       = '0;
            d.strap_vld = 1'b0;
            d.pass      = 1'b0;
            d.cfg_ok    = 1'b0;
        end else begin
            if (!q.strap_vld) begin
                d.strap     = strap;
                d.strap_vld = 1'b1;
            end
            unique case (q.st)
                ST_IDLE: begin
                    if (go_ok) begin
                        d.st  = ST_PRB1;
                        d.cnt = '0;
                    end
                end
                ST_PRB1: begin
                    if (!go_ok) begin
                        d.st = ST_IDLE;
                    end else if (q.cnt == PULSE_LAST) begin
                        d.cap1 = det_s;
                        d.st   = ST_PRB2;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PRB2: begin
                    if (!go_ok) begin
                        d.st = ST_IDLE;
                    end else if (q.cnt == PULSE_LAST) begin
                        d.pass = (q.cap1 == m1) && (det_s == m2);
                        d.st   = ST_WAIT;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (!go_ok) begin
                        d.st = ST_IDLE;
                    end else if (q.cnt == GAP_LAST) begin
                        d.cnt = '0;
                        if (q.pass) begin
                            d.st     = ST_DONE;
                            d.cfg_ok = 1'b1;
                        end else begin
                            d.st = ST_PRB1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    d.st = ST_DONE;
                end
            endcase
        end
        d.grant = {2{d.cfg_ok && sys_en && pwr_ok}} & ch_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.cnt       <= '0;
            q.strap     <= '0;
            q.strap_vld <= 1'b0;
            q.cap1      <= '0;
            q.pass      <= 1'b0;
            q.cfg_ok    <= 1'b0;
            q.grant     <= '0;
        end else begin
            q <= d;
        end
    end

    assign probe_req = {q.st == ST_PRB2, q.st == ST_PRB1};
    assign pd_en     = (q.st == ST_PRB1 || q.st == ST_PRB2) ? PD_MASK : '0;
    assign ss_grant  = q.grant;
    assign cfg_ok    = q.cfg_ok;

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.strap_vld && bias_ok) |=> $stable(q.strap));

    // R3
    probe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_req[0]) |-> $past(go_ok));

    // R4
    probe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(probe_req[0]) && $past(go_ok)) |-> probe_req[1]);

    // R7
    pass_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_ok) |-> $past(q.st == ST_WAIT && q.pass));

    // R9
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && bias_ok) |=> cfg_ok);

    // R10
    grant_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ss_grant & ~$past(ch_en))) == 1'b0);

endmodule

// File: tb/pstage_cfg_seq_test.sv
`timescale 1ns/1ps
module pstage_cfg_seq_test;
    localparam int PULSE = 4;
    localparam int GAP   = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bias_ok, pwr_ok, sys_en;
    logic [1:0] ch_en, strap;
    logic [5:0] stage_det;
    logic [1:0] probe_req;
    logic [5:0] pd_en;
    logic [1:0] ss_grant;
    logic       cfg_ok;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int node [6];

    always #2.5 clk = ~clk;

    pstage_cfg_seq #(.PULSE_CYC(PULSE), .GAP_CYC(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .pwr_ok(pwr_ok),
        .sys_en(sys_en), .ch_en(ch_en), .strap(strap), .stage_det(stage_det),
        .probe_req(probe_req), .pd_en(pd_en), .ss_grant(ss_grant), .cfg_ok(cfg_ok)
    );

    // board wiring model: stages on one node see each other's pulse
    always_comb begin
        for (int i = 0; i < 6; i++)
            stage_det[i] = (probe_req[0] && node[i] == node[1]) ||
                           (probe_req[1] && node[i] == node[4]);
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // wiring per code: 0..3 partition, 4 = masters shorted
    task automatic wire_as(input int w);
        for (int st = 1; st <= 6; st++) begin
            bit on2;
            case (w)
                3: on2 = (st >= 4);
                2: on2 = (st >= 5);
                1: on2 = (st == 5);
                default: on2 = (st >= 3);
            endcase
            node[st-1] = (w == 4) ? 1 : (on2 ? 2 : 1);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bias_ok = 1'b0; pwr_ok = 1'b0; sys_en = 1'b0;
        ch_en = 2'b00; strap = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_probe(input string rq);
        int t = 0;
        while (probe_req != 2'b01 && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(probe_req == 2'b01, rq, int'(probe_req), 1);
    endtask

    task automatic probe_phase();
        int n1 = 0;
        int n2 = 0;
        while (probe_req == 2'b01 && n1 < 100) begin
            if (n1 == 0) chk(pd_en == 6'b101101, "R5", int'(pd_en), 45);
            n1++;
            @(negedge clk);
        end
        chk(n1 == PULSE, "R4", n1, PULSE);
        while (probe_req == 2'b10 && n2 < 100) begin
            n2++;
            @(negedge clk);
        end
        chk(n2 == PULSE, "R4", n2, PULSE);
        chk(pd_en == 6'b0 && probe_req == 2'b00, "R5", int'(pd_en), 0);
    endtask

    task automatic gap_phase(input bit exp_pass, input string rq);
        repeat (GAP - 1) @(negedge clk);
        chk(cfg_ok == 1'b0 && probe_req == 2'b00, rq, int'(cfg_ok), 0);
        @(negedge clk);
        if (exp_pass) chk(cfg_ok == 1'b1, rq, int'(cfg_ok), 1);
        else chk(probe_req == 2'b01 && cfg_ok == 1'b0, rq, int'(probe_req), 1);
    endtask

    task automatic power_up(input int s);
        strap = 2'(s); ch_en = 2'b11; sys_en = 1'b1; pwr_ok = 1'b1; bias_ok = 1'b1;
    endtask

    initial begin
        wire_as(3);
        do_reset();
        // reset state
        chk(probe_req == 0 && pd_en == 0 && ss_grant == 0 && cfg_ok == 0,
            "R11", int'(cfg_ok), 0);

        // R1 / R6 / R8: every strap against every wiring
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 5; w++) begin
                do_reset();
                wire_as(w);
                power_up(s);
                wait_probe("R3");
                probe_phase();
                if (w == s) begin
                    gap_phase(1'b1, "R1");
                    chk(ss_grant == 2'b11, "R10", int'(ss_grant), 3);
                end else begin
                    gap_phase(1'b0, "R6");
                    probe_phase();
                    gap_phase(1'b0, "R8");
                end
            end
        end

        // R3: start gating
        do_reset();
        wire_as(2);
        power_up(2);
        ch_en = 2'b00;
        repeat (20) @(negedge clk);
        chk(probe_req == 0, "R3", int'(probe_req), 0);
        ch_en = 2'b01; sys_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(probe_req == 0, "R3", int'(probe_req), 0);
        sys_en = 1'b1; pwr_ok = 1'b0;
        repeat (20) @(negedge clk);
        chk(probe_req == 0, "R3", int'(probe_req), 0);
        pwr_ok = 1'b1;
        wait_probe("R3");
        probe_phase();
        gap_phase(1'b1, "R3");
        chk(ss_grant == 2'b01, "R10", int'(ss_grant), 1);

        // R9: re-enable after pass, no probing
        ch_en = 2'b00;
        @(negedge clk);
        chk(ss_grant == 2'b00 && cfg_ok, "R10", int'(ss_grant), 0);
        repeat (30) @(negedge clk);
        chk(probe_req == 0 && cfg_ok, "R9", int'(probe_req), 0);
        ch_en = 2'b10;
        @(negedge clk);
        chk(ss_grant == 2'b10 && probe_req == 0, "R9", int'(ss_grant), 2);
        sys_en = 1'b0;
        @(negedge clk);
        chk(ss_grant == 2'b00 && cfg_ok, "R10", int'(ss_grant), 0);
        sys_en = 1'b1;

        // R2: strap pins ignored after capture, recaptured after bias loss
        do_reset();
        wire_as(2);
        power_up(2);
        repeat (2) @(negedge clk);
        strap = 2'b00;
        wait_probe("R2");
        probe_phase();
        gap_phase(1'b1, "R2");
        bias_ok = 1'b0;
        @(negedge clk);
        chk(cfg_ok == 0 && ss_grant == 0, "R11", int'(cfg_ok), 0);
        bias_ok = 1'b1;
        wait_probe("R2");
        probe_phase();
        gap_phase(1'b0, "R2");
        wire_as(0);
        probe_phase();
        gap_phase(1'b1, "R2");

        // R12: abort mid-probe and restart
        do_reset();
        wire_as(1);
        power_up(1);
        wait_probe("R12");
        @(negedge clk);
        ch_en = 2'b00;
        @(negedge clk);
        chk(probe_req == 0 && pd_en == 0, "R12", int'(probe_req), 0);
        repeat (5) @(negedge clk);
        chk(probe_req == 0, "R12", int'(probe_req), 0);
        ch_en = 2'b01;
        wait_probe("R12");
        probe_phase();
        gap_phase(1'b1, "R12");

        // R11: bias loss on the very edge the wait would pass
        do_reset();
        wire_as(3);
        power_up(3);
        wait_probe("R11");
        probe_phase();
        repeat (GAP - 1) @(negedge clk);
        bias_ok = 1'b0;
        @(negedge clk);
        chk(cfg_ok == 0 && ss_grant == 0, "R11", int'(cfg_ok), 0);
        repeat (3) @(negedge clk);
        chk(cfg_ok == 0 && probe_req == 0, "R11", int'(cfg_ok), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule